// File: doc/BRIEF.md
# Dual-Issue Pairing Slot Tracker

This block watches a stream of retiring instructions, one per clock at most, and decides for each one whether it can share an issue cycle with the instructions already grouped or must begin a fresh issue cycle. It is meant to model the pairing limits of a two-wide issue stage. Each instruction arrives with a functional-unit class code, a valid strobe and a dependency flag. The dependency flag means the instruction needs the result of the one just before it.

The tracker keeps a remaining-slot quota for every class and a shared count of slots left in the current cycle. When an instruction cannot fit, a new group opens: every quota is refilled and the shared count is restored. The instruction then takes one slot from its own class and one from the shared count. Two running totals are kept. One counts the issue cycles opened. The other counts the cycles that were opened because of a dependency.

Top module: `pair_slot_tracker`

## Requirements
- R1: After reset `groupStart` is 0, `slotsLeft` is 0 and both counters are 0. All class quotas are 0, so the first valid instruction always opens a group.
- R2: A valid instruction opens a new group when its class quota is 0, when `depHazard` is 1, or when `slotsLeft` is 0. Otherwise it joins the current group.
- R3: Opening a group restores the shared count to `GROUP_SLOTS` (2) before the opener consumes its slot. `slotsLeft` is therefore 1 right after an opening instruction.
- R4: On a group open, class codes 2 (compare), 3 (branch) and 4 (jump) are refilled to a quota of 1, and every other class to 2. Each accepted instruction takes one from its own class quota after any refill. A second compare, branch or jump in the same group therefore opens a new group.
- R5: `issueCount` rises by exactly one for each valid instruction that opens a group and is unchanged otherwise.
- R6: `hazardCount` rises by one for each valid instruction with `depHazard` set, every such instruction opens a group, and `hazardCount` never exceeds `issueCount`.
- R7: While `instValid` is 0, no quota, count or counter changes, `groupStart` is 0, and `depHazard` and `instClass` are ignored.
- R8: `groupStart` is a registered flag, 1 in the cycle after the clock edge that accepted a group-opening instruction. Class codes 20 to 31 are treated as class 0 with the wide quota.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is presented this cycle |
| instClass | input | 5 | Functional-unit class code |
| depHazard | input | 1 | Instruction depends on its predecessor |
| groupStart | output | 1 | Last accepted instruction opened a group |
| slotsLeft | output | 2 | Shared slots remaining in the current group |
| issueCount | output | 16 | Issue cycles opened since reset |
| hazardCount | output | 16 | Groups opened by a dependency |

## Verification
Every result is registered. `groupStart`, `slotsLeft` and both counters all reflect an instruction one clock edge after it is presented. The driver presents each instruction on a falling edge and pushes the predicted outputs into a queue. The monitor waits one time unit past the next rising edge, pops the queued prediction and compares all four outputs against it. Predictions come from a separate per-class quota model in the bench, so each item lines up with exactly the edge that consumed it.

// File: rtl/pair_slot_pkg.sv
package pair_slot_pkg;

  localparam int CLS_COMPARE = 2;
  localparam int CLS_BRANCH  = 3;
  localparam int CLS_JUMP    = 4;

  typedef struct packed {
    logic accept;
    logic open;
    logic hazOpen;
  } slot_strobe_t;

  function automatic int reloadFor(input int idx, input int wide, input int narrow);
    if (idx == CLS_COMPARE || idx == CLS_BRANCH || idx == CLS_JUMP)
      return narrow;
    return wide;
  endfunction

endpackage

// File: rtl/pair_slot_ctrl.sv
module pair_slot_ctrl
  import pair_slot_pkg::*;
#(
  parameter int NUM_CLASSES = 20,
  parameter int CLASS_W     = 5,
  parameter int QW          = 2,
  parameter int SLOT_W      = 2,
  parameter int IDX_W       = $clog2(NUM_CLASSES)
) (
  input  logic               instValid,
  input  logic [CLASS_W-1:0] instClass,
  input  logic               depHazard,
  input  logic [QW-1:0]      curQuota,
  input  logic [SLOT_W-1:0]  slotsLeft,
  output logic [IDX_W-1:0]   classSel,
  output slot_strobe_t       strobe
);

  logic inRange;
  logic noRoom;

  assign inRange  = instClass < CLASS_W'(NUM_CLASSES);
  assign classSel = inRange ? IDX_W'(instClass) : '0;

  // Any one of three conditions forces a fresh issue cycle.
  assign noRoom = (curQuota == '0) || (slotsLeft == '0) || depHazard;

  always_comb begin
    strobe.accept  = instValid;
    strobe.open    = instValid && noRoom;
    strobe.hazOpen = instValid && depHazard;
  end

endmodule

// File: rtl/pair_slot_datapath.sv
module pair_slot_datapath
  import pair_slot_pkg::*;
#(
  parameter int NUM_CLASSES  = 20,
  parameter int GROUP_SLOTS  = 2,
  parameter int WIDE_QUOTA   = 2,
  parameter int NARROW_QUOTA = 1,
  parameter int CNT_W        = 16,
  parameter int QW           = 2,
  parameter int SLOT_W       = 2,
  parameter int IDX_W        = $clog2(NUM_CLASSES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_strobe_t      strobe,
  input  logic [IDX_W-1:0]  classSel,
  output logic [QW-1:0]     curQuota,
  output logic [SLOT_W-1:0] slotsLeft,
  output logic              groupStart,
  output logic [CNT_W-1:0]  issueCount,
  output logic [CNT_W-1:0]  hazardCount
);

  localparam logic [SLOT_W-1:0] SLOT_RELOAD = SLOT_W'(GROUP_SLOTS);

  logic [NUM_CLASSES-1:0][QW-1:0] quotaVec;

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_quota
    localparam logic [QW-1:0] RELOAD_Q = QW'(reloadFor(g, WIDE_QUOTA, NARROW_QUOTA));
    logic [QW-1:0] quotaQ;
    logic          hit;

    assign hit = (classSel == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        quotaQ <= '0;
      end else if (strobe.accept) begin
        if (strobe.open)
          quotaQ <= hit ? RELOAD_Q - QW'(1) : RELOAD_Q;
        else if (hit)
          quotaQ <= quotaQ - QW'(1);
      end
    end

    assign quotaVec[g] = quotaQ;
  end

  assign curQuota = quotaVec[classSel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotsLeft   <= '0;
      groupStart  <= 1'b0;
      issueCount  <= '0;
      hazardCount <= '0;
    end else begin
      groupStart <= strobe.accept && strobe.open;
      if (strobe.accept) begin
        slotsLeft <= strobe.open ? SLOT_RELOAD - SLOT_W'(1) : slotsLeft - SLOT_W'(1);
        if (strobe.open)
          issueCount <= issueCount + CNT_W'(1);
        if (strobe.hazOpen)
          hazardCount <= hazardCount + CNT_W'(1);
      end
    end
  end

  // R3: the shared count never exceeds one group's worth of slots
  a_r3_slots_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    slotsLeft <= SLOT_RELOAD);

  // R5: an opening strobe advances the issue counter by exactly one
  a_r5_issue_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.accept && strobe.open) |=> issueCount == $past(issueCount) + CNT_W'(1));

  // R5: no opening strobe, no change to the issue counter
  a_r5_issue_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.accept && strobe.open) |=> $stable(issueCount));

endmodule

// File: rtl/pair_slot_tracker.sv
module pair_slot_tracker
  import pair_slot_pkg::*;
#(
  parameter int NUM_CLASSES  = 20,
  parameter int CLASS_W      = 5,
  parameter int GROUP_SLOTS  = 2,
  parameter int WIDE_QUOTA   = 2,
  parameter int NARROW_QUOTA = 1,
  parameter int CNT_W        = 16,
  parameter int SLOT_W       = $clog2(GROUP_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instValid,
  input  logic [CLASS_W-1:0] instClass,
  input  logic               depHazard,
  output logic               groupStart,
  output logic [SLOT_W-1:0]  slotsLeft,
  output logic [CNT_W-1:0]   issueCount,
  output logic [CNT_W-1:0]   hazardCount
);

  localparam int MAX_QUOTA = (WIDE_QUOTA > NARROW_QUOTA) ? WIDE_QUOTA : NARROW_QUOTA;
  localparam int QW        = $clog2(MAX_QUOTA + 1);
  localparam int IDX_W     = $clog2(NUM_CLASSES);

  slot_strobe_t     strobe;
  logic [IDX_W-1:0] classSel;
  logic [QW-1:0]    curQuota;

  pair_slot_ctrl #(
    .NUM_CLASSES(NUM_CLASSES), .CLASS_W(CLASS_W), .QW(QW),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .instValid(instValid), .instClass(instClass), .depHazard(depHazard),
    .curQuota(curQuota), .slotsLeft(slotsLeft),
    .classSel(classSel), .strobe(strobe)
  );

  pair_slot_datapath #(
    .NUM_CLASSES(NUM_CLASSES), .GROUP_SLOTS(GROUP_SLOTS),
    .WIDE_QUOTA(WIDE_QUOTA), .NARROW_QUOTA(NARROW_QUOTA),
    .CNT_W(CNT_W), .QW(QW), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .classSel(classSel),
    .curQuota(curQuota), .slotsLeft(slotsLeft), .groupStart(groupStart),
    .issueCount(issueCount), .hazardCount(hazardCount)
  );

  // R2: a dependency always opens a group
  a_r2_hazard_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && depHazard) |=> groupStart);

  // R3: an opener leaves one slot fewer than a full group
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    groupStart |-> slotsLeft == SLOT_W'(GROUP_SLOTS - 1));

  // R6: dependency-opened groups are a subset of all groups
  a_r6_hazard_le_issue: assert property (@(posedge clk) disable iff (!rst_n)
    hazardCount <= issueCount);

  // R7: an idle cycle changes nothing
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instValid |=> ($stable(issueCount) && $stable(hazardCount) &&
                    $stable(slotsLeft) && !groupStart));

endmodule

// File: tb/pair_slot_tracker_bench.sv
module pair_slot_tracker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instValid = 1'b0;
  logic [4:0]  instClass = '0;
  logic        depHazard = 1'b0;
  logic        groupStart;
  logic [1:0]  slotsLeft;
  logic [15:0] issueCount;
  logic [15:0] hazardCount;

  always #2.5 clk = ~clk;

  pair_slot_tracker u_pair_slot_tracker (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instClass(instClass),
    .depHazard(depHazard), .groupStart(groupStart), .slotsLeft(slotsLeft),
    .issueCount(issueCount), .hazardCount(hazardCount)
  );

  typedef struct {
    string tag;
    logic  start;
    int    slots;
    int    issue;
    int    haz;
  } exp_t;

  exp_t expQ[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  int mQuota[20];
  int mSlots = 0;
  int mIssue = 0;
  int mHaz   = 0;

  function automatic int refill(input int idx);
    return (idx == 2 || idx == 3 || idx == 4) ? 1 : 2;
  endfunction

  task automatic send(input bit v, input int cls, input bit haz, input string tag);
    exp_t e;
    int   idx;
    bit   opens;
    @(negedge clk);
    instValid = v;
    instClass = 5'(cls);
    depHazard = haz;
    e.tag = tag;
    e.start = 1'b0;
    if (v) begin
      idx = (cls < 20) ? cls : 0;
      opens = (mQuota[idx] == 0) || haz || (mSlots == 0);
      if (opens) begin
        for (int i = 0; i < 20; i++) mQuota[i] = refill(i);
        mSlots = 2;
        mIssue++;
        if (haz) mHaz++;
      end
      mQuota[idx]--;
      mSlots--;
      e.start = opens;
    end
    e.slots = mSlots;
    e.issue = mIssue;
    e.haz   = mHaz;
    expQ.push_back(e);
  endtask

  // Monitor: results are due one edge after the driving negedge
  always @(posedge clk) begin
    #1;
    if (rst_n && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      tests++;
      if (groupStart !== e.start || int'(slotsLeft) != e.slots ||
          int'(issueCount) != e.issue || int'(hazardCount) != e.haz) begin
        fails++;
        $display("FAIL %s: start=%0b slots=%0d issue=%0d haz=%0d expected start=%0b slots=%0d issue=%0d haz=%0d",
                 e.tag, groupStart, slotsLeft, issueCount, hazardCount,
                 e.start, e.slots, e.issue, e.haz);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20; i++) mQuota[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    tests++;
    if (groupStart !== 1'b0 || slotsLeft !== 2'd0 || issueCount !== 16'd0 || hazardCount !== 16'd0) begin
      fails++;
      $display("FAIL R1 reset: start=%0b slots=%0d issue=%0d haz=%0d expected 0 0 0 0",
               groupStart, slotsLeft, issueCount, hazardCount);
    end
    rst_n = 1'b1;
    send(1, 9, 0, "R1 first opens");
    send(1, 9, 0, "R3 second joins");
    send(1, 7, 0, "R2 slots empty");
    send(1, 2, 0, "R4 compare joins");
    send(1, 2, 0, "R4 compare opens");
    send(1, 2, 0, "R2 quota exhausted");
    send(1, 3, 0, "R4 branch joins");
    send(1, 10, 1, "R6 hazard opens");
    send(1, 10, 1, "R6 hazard again");
    send(0, 2, 1, "R7 idle ignored");
    send(0, 4, 1, "R7 idle ignored");
    send(1, 11, 0, "R7 state kept");
    send(1, 4, 0, "R5 jump opens");
    send(1, 4, 0, "R5 jump twice");
    send(1, 25, 0, "R8 high code");
    send(1, 3, 0, "R8 branch opens");
    send(1, 0, 0, "R4 default joins");
    send(0, 0, 0, "R7 idle end");
    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule